// File: doc/BRIEF.md
# Packed Lane Multiplier with Pairwise Accumulate

This unit multiplies the four 16-bit lanes of two 64-bit operands in parallel and returns one of several views of the products. These views are the low half of each signed product, the high half of each signed or unsigned product, or the sums of neighbouring signed products packed as two 32-bit lanes. The same four lane multipliers are also rearranged into a single unsigned 32x32 multiply whose full 64-bit product comes back as one result.

Operations enter on a valid/ready stream and leave on a second valid/ready stream. The pipeline has two register stages. When the consumer keeps `out_ready` high, a new operation is accepted on every clock and its result appears two edges later. When the consumer deasserts `out_ready` while a result is waiting, the whole pipeline freezes and `in_ready` falls in the same cycle. The waiting result then stays unchanged until it is taken. A transfer happens on a rising edge where valid and ready are both high. Saturation of the accumulate sums and floating-point formats are not handled.

Top module: `pmul_unit`

## Requirements
- R1: Opcode 0 (low): result lane i (bits 16i+15..16i, i = 0..3) holds the low 16 bits of the signed product of operand lanes i.
- R2: Opcode 1 (signed high): result lane i holds bits 31..16 of the signed 32-bit product of operand lanes i.
- R3: Opcode 2 (unsigned high): result lane i holds bits 31..16 of the unsigned product of operand lanes i.
- R4: Opcode 3 (pair sum): result bits 31..0 equal the sum of the signed products of lanes 0 and 1, and bits 63..32 equal the sum for lanes 2 and 3, both wrapping modulo 2^32. With every input lane at -32768, each half reads 0x80000000.
- R5: Opcode 4 (wide): the result is the full unsigned 64-bit product of bits 31..0 of both operands. Bits 63..32 of the operands have no effect.
- R6: With `out_ready` high, an operation accepted at edge t gives `out_valid` high with its result after edge t+2. A new operation can be accepted at every edge, and results leave in order of acceptance.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. `in_ready` equals `!out_valid || out_ready`.
- R8: Opcodes 5, 6 and 7 are reserved. They produce an all-zero result, which still goes through the pipeline with valid.
- R9: While reset is held, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (0..4 defined, 5..7 reserved) |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result |

## Verification
A wrong lane routing or sign selection corrupts the matching result lane of the first operation that uses that mode. That result is compared at the port two edges after it is accepted. A lost or duplicated pipeline valid shows up as an out-of-order or missing result, or as an extra result, at the next transfer. A stall that fails to freeze both stages changes `out_data` on the very next edge while `out_valid` is high and `out_ready` is low. Random back-pressure is mixed with dense lane corner values (0x8000, 0x7FFF, 0xFFFF, 0) so that these states come up often.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;
  localparam int PROD_W = 2 * LANE_W;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LO    = 3'd0,
    OP_HI_S  = 3'd1,
    OP_HI_U  = 3'd2,
    OP_PAIR  = 3'd3,
    OP_WIDE  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } pmul_op_e;

  function automatic logic op_is_signed(pmul_op_e op);
    return (op == OP_LO) || (op == OP_HI_S) || (op == OP_PAIR);
  endfunction
endpackage

// File: rtl/pmul_route.sv
module pmul_route
  import pmul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES
) (
  input  pmul_op_e                 op,
  input  logic [NL*LW-1:0]         a,
  input  logic [NL*LW-1:0]         b,
  output logic [NL-1:0][LW-1:0]    lane_a,
  output logic [NL-1:0][LW-1:0]    lane_b,
  output logic                     lane_sgn
);
  // Wide mode builds a 2LW x 2LW product from four LW x LW partials:
  // lane i takes half (i mod 2) of a and half (i div 2) of b.
  always_comb begin
    lane_sgn = op_is_signed(op);
    for (int i = 0; i < NL; i++) begin
      if (op == OP_WIDE) begin
        if (i < 4) begin
          lane_a[i] = a[(i % 2)*LW +: LW];
          lane_b[i] = b[((i / 2) % 2)*LW +: LW];
        end else begin
          lane_a[i] = '0;
          lane_b[i] = '0;
        end
      end else begin
        lane_a[i] = a[i*LW +: LW];
        lane_b[i] = b[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int LW = 16,
  localparam int PW = 2 * LW
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sgn,
  output logic [PW-1:0] prod
);
  logic signed [LW:0]   ext_a;
  logic signed [LW:0]   ext_b;
  logic signed [PW-1:0] full;

  // One extra bit turns both signed and unsigned operands into signed ones;
  // either product fits in PW bits, so truncation loses nothing.
  assign ext_a = $signed({sgn & a[LW-1], a});
  assign ext_b = $signed({sgn & b[LW-1], b});
  assign full  = PW'(ext_a) * PW'(ext_b);
  assign prod  = full;
endmodule

// File: rtl/pmul_combine.sv
module pmul_combine
  import pmul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES,
  localparam int PW = 2 * LW,
  localparam int DW = NL * LW
) (
  input  pmul_op_e              op,
  input  logic [NL-1:0][PW-1:0] prods,
  output logic [DW-1:0]         result
);
  logic [DW-1:0] wide_sum;

  always_comb begin
    wide_sum = '0;
    if (NL >= 4) begin
      wide_sum = DW'(prods[0])
               + (DW'(prods[1]) << LW)
               + (DW'(prods[2]) << LW)
               + (DW'(prods[3]) << (2*LW));
    end
  end

  always_comb begin
    result = '0;
    case (op)
      OP_LO: begin
        for (int i = 0; i < NL; i++) result[i*LW +: LW] = prods[i][LW-1:0];
      end
      OP_HI_S, OP_HI_U: begin
        for (int i = 0; i < NL; i++) result[i*LW +: LW] = prods[i][PW-1:LW];
      end
      OP_PAIR: begin
        for (int j = 0; j < NL/2; j++)
          result[j*PW +: PW] = prods[2*j] + prods[2*j+1];
      end
      OP_WIDE: result = wide_sum;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES,
  localparam int PW = 2 * LW,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  pmul_op_e              op_in;
  logic [NL-1:0][LW-1:0] lane_a;
  logic [NL-1:0][LW-1:0] lane_b;
  logic                  lane_sgn;
  logic [NL-1:0][PW-1:0] lane_prod;

  logic                  s1_valid;
  pmul_op_e              s1_op;
  logic [NL-1:0][PW-1:0] s1_prod;
  logic [DW-1:0]         s1_result;
  logic                  advance;

  assign op_in    = pmul_op_e'(in_op);
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  pmul_route #(.LW(LW), .NL(NL)) u_route (
    .op       (op_in),
    .a        (in_a),
    .b        (in_b),
    .lane_a   (lane_a),
    .lane_b   (lane_b),
    .lane_sgn (lane_sgn)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    pmul_lane #(.LW(LW)) u_lane (
      .a    (lane_a[g]),
      .b    (lane_b[g]),
      .sgn  (lane_sgn),
      .prod (lane_prod[g])
    );
  end

  // Stage 1: lane products
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_LO;
      s1_prod  <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op   <= op_in;
        s1_prod <= lane_prod;
      end
    end
  end

  pmul_combine #(.LW(LW), .NL(NL)) u_combine (
    .op     (s1_op),
    .prods  (s1_prod),
    .result (s1_result)
  );

  // Stage 2: formatted result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_result;
    end
  end
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  // R6: accepted operation is valid at the output two advancing edges later
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // R7: a stalled result holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: an empty output stage never refuses input
  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8: reserved opcodes give zero
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 3'd5) ##1 in_ready |=> out_data == '0);

  // R1: a zero first operand makes every product zero
  assert_zero_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == '0) ##1 in_ready |=> out_data == '0);

  // R9: reset leaves the output empty
  assert_reset_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind pmul_unit pmul_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/pmul_unit_bench.sv
module pmul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_q[$];
  logic [2:0]  op_q[$];

  always #5 clk = ~clk;

  pmul_unit u_pmul_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int sp [4];
    int unsigned up [4];
    r = '0;
    for (int i = 0; i < 4; i++) begin
      logic signed [15:0] sa, sb;
      logic [15:0] ua, ub;
      sa = a[16*i +: 16]; sb = b[16*i +: 16];
      ua = a[16*i +: 16]; ub = b[16*i +: 16];
      sp[i] = int'(sa) * int'(sb);
      up[i] = 32'(ua) * 32'(ub);
    end
    case (op)
      3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = sp[i][15:0];
      3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = sp[i][31:16];
      3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = up[i][31:16];
      3'd3: begin
        r[31:0]  = 32'(sp[0] + sp[1]);
        r[63:32] = 32'(sp[2] + sp[3]);
      end
      3'd4: r = {32'd0, a[31:0]} * {32'd0, b[31:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Single operation with exact latency check (R6) and value check
  task automatic run_one(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [63:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_a = '0; in_b = '0;
    check("R6", {63'd0, out_valid}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6", {63'd0, out_valid}, 64'd1);
    check(req_of(op), out_data, exp);
    check(req_of(op), out_data, model(op, a, b));
  endtask

  function automatic logic [15:0] lane_val();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic        stalled;
    logic [63:0] held;
    void'($urandom(32'h5EED_1234));

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", {62'd0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;

    // Directed corners
    run_one(3'd0, 64'h0003_FFFF_8000_7FFF, 64'h0005_FFFF_8000_7FFF, 64'h000F_0001_0000_0001); // R1
    run_one(3'd1, 64'hFFFF_8000_7FFF_8000, 64'hFFFF_8000_7FFF_7FFF, 64'h0000_4000_3FFF_C000); // R2
    run_one(3'd2, 64'hFFFF_8000_0002_1234, 64'hFFFF_8000_8000_0001, 64'hFFFE_4000_0001_0000); // R3
    run_one(3'd3, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h8000_0000_8000_0000); // R4
    run_one(3'd3, 64'h0002_FFFF_0003_0004, 64'h0005_0001_0006_0007, 64'h0000_0009_0000_002E); // R4
    run_one(3'd4, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 64'hFFFF_FFFE_0000_0001); // R5
    run_one(3'd4, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_0001_0000, 64'h0000_0001_0000_0000); // R5
    run_one(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);                   // R8

    // Random stream with back-pressure (R6 order, R7 hold)
    stalled = 1'b0;
    held = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      out_ready = (cyc < 400) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (stalled) check("R7", {out_valid, out_data[62:0]}, {1'b1, held[62:0]});
      if (stalled) check("R7", out_data, held);
      check("R7", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R6", 64'd1, 64'd0);
        end else begin
          check(req_of(op_q[0]), out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(op_q.pop_front());
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
      if (in_ready && (cyc < 400 || ($urandom % 5) != 0)) begin
        logic [2:0]  op;
        logic [63:0] a, b;
        op = 3'($urandom % 8);
        for (int i = 0; i < 4; i++) begin
          a[16*i +: 16] = lane_val();
          b[16*i +: 16] = lane_val();
        end
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        exp_q.push_back(model(op, a, b));
        op_q.push_back(op);
      end else begin
        in_valid = 1'b0;
      end
    end

    // Drain
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (out_valid) begin
        if (exp_q.size() == 0) check("R6", 64'd1, 64'd0);
        else begin
          check(req_of(op_q[0]), out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(op_q.pop_front());
        end
      end
      @(negedge clk);
    end
    check("R6", 64'(exp_q.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule